// File: doc/BRIEF.md
# Code Write-Protect Filter

This block sits behind address translation on the store path and decides whether a store is about to overwrite guest code for which translations exist. Each store arrives with its real (translated) address and the write-protect bit of the TLB entry that translated it. Stores to pages without that bit pass silently. A protected store is then looked up by its real page number in a small fine-grained table. Each entry of that table holds a 16-bit mask in which one bit stands for one 256-byte slice of a 4 KiB page. A code-write fault is raised only if the slice the store lands in is marked. A protected store whose page is missing from the fine table raises a separate, coarse page-level fault.

A second table lists the real pages that hold guest code. Writes from I/O agents are presented on their own port, and a write that lands in any listed page raises an interrupt towards the management software. Both tables are loaded and invalidated one entry per cycle through a plain configuration port. All fault and interrupt outputs are registered one-cycle pulses, and each one latches the offending address, which is held until the next event of the same kind.

The store input is a valid/ready stream whose `st_ready` is always high: the filter never applies back-pressure, and every cycle with `st_valid` high counts as one store. The I/O write port has a valid bit only and cannot stall.

Top module: `cwp_code_write_filter`

## Requirements
- R1: After reset both tables are empty, `flt_code`, `flt_page` and `io_irq` are low, and `flt_addr` and `io_irq_addr` are zero.
- R2: A store presented with `st_wp` low never raises `flt_code` or `flt_page`, whatever the table contents.
- R3: A store with `st_wp` high whose real page number (`st_paddr[31:12]`) matches a valid fine-table entry, and whose mask bit indexed by `st_paddr[11:8]` is 1, pulses `flt_code` high for exactly the next cycle, and `flt_addr` then shows the full store address.
- R4: A store with `st_wp` high that matches a valid fine-table entry whose indexed mask bit is 0 raises no fault.
- R5: A store with `st_wp` high whose page matches no valid fine-table entry pulses `flt_page` for the next cycle and latches its address in `flt_addr`; `flt_code` and `flt_page` are never high together.
- R6: Writing an entry with `cfg_valid` low invalidates it, so later protected stores to its page take the coarse fault of R5.
- R7: A configuration write (`cfg_we` high, `cfg_sel` 0 selects the fine table, 1 the I/O code-page table, `cfg_idx` the entry) takes effect for stores presented in the following cycle; a store presented in the same cycle as the write sees the old contents.
- R8: An `io_valid` write whose page matches a valid entry of the I/O code-page table pulses `io_irq` for the next cycle and latches `io_paddr` in `io_irq_addr`; writes to other pages, including pages only listed in the fine table, raise nothing.
- R9: `flt_addr` and `io_irq_addr` keep their value in every cycle without a new fault or interrupt of their own kind.
- R10: A cycle with `st_valid` low raises no fault, even if `st_paddr` and `st_wp` would fault; `st_ready` is always high.
- R11: When several valid fine-table entries carry the same page number, their masks combine by OR for the slice check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store present this cycle |
| st_ready | output | 1 | Always high: the filter accepts every store |
| st_paddr | input | 32 | Real address of the store after translation |
| st_wp | input | 1 | Write-protect bit of the TLB entry that translated the store |
| io_valid | input | 1 | I/O write present this cycle |
| io_paddr | input | 32 | Real address of the I/O write |
| cfg_we | input | 1 | Table write strobe, one entry per cycle |
| cfg_sel | input | 1 | Table select: 0 fine table, 1 I/O code-page table |
| cfg_idx | input | 3 | Entry index |
| cfg_valid | input | 1 | 1 loads the entry, 0 invalidates it |
| cfg_ppn | input | 20 | Real page number written to the entry |
| cfg_mask | input | 16 | Slice mask (fine table only) |
| flt_code | output | 1 | Code-write fault pulse |
| flt_page | output | 1 | Coarse page-level fault pulse |
| flt_addr | output | 32 | Address of the most recent fault |
| io_irq | output | 1 | Interrupt pulse for an I/O write to a code page |
| io_irq_addr | output | 32 | Address of the most recent interrupting I/O write |

## Verification
The hardest situation to reach is a store and a table update to the same page in the same cycle, where the outcome depends on which side of the clock edge the table change lands. The bench drives the write and the protected store together at one falling edge and expects the old verdict, then repeats the store and expects the new one. Beyond that, it sweeps every entry of both tables and every 256-byte slice with the write-protect bit in both states. It also places a duplicate page in two entries to reach the mask merge.

// File: rtl/cwp_pkg.sv
package cwp_pkg;

  // Which table a configuration write addresses.
  typedef enum logic {
    TBL_FINE = 1'b0,
    TBL_IO   = 1'b1
  } tbl_sel_e;

  // Verdict of the filter for one store.
  typedef struct packed {
    logic code_hit;
    logic page_hit;
  } verdict_t;

endpackage

// File: rtl/cwp_tag_table.sv
// Small fully associative table: tag, valid bit and a mask per entry.
// Lookup is combinational against registered contents, so a write
// becomes visible one cycle later. Matching masks are OR-merged.
module cwp_tag_table #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 20,
  parameter int MASK_W  = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [MASK_W-1:0] wr_mask,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [MASK_W-1:0] lk_mask
);

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [MASK_W-1:0]  mask_q [ENTRIES];
  logic [ENTRIES-1:0] match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i]  <= '0;
        mask_q[i] <= '0;
      end
    end else if (wr_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (wr_idx == IDX_W'(i)) begin
          vld_q[i]  <= wr_valid;
          tag_q[i]  <= wr_tag;
          mask_q[i] <= wr_mask;
        end
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (tag_q[g] == lk_tag);
  end

  always_comb begin
    lk_mask = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) lk_mask = lk_mask | mask_q[i];
    end
  end

  assign lk_hit = |match;

endmodule

// File: rtl/cwp_compare.sv
// Decides between no fault, fine code fault and coarse page fault.
module cwp_compare
  import cwp_pkg::*;
#(
  parameter int SUB_W   = 4,
  localparam int MASK_W = 1 << SUB_W
) (
  input  logic              st_fire,
  input  logic              st_wp,
  input  logic              tbl_hit,
  input  logic [MASK_W-1:0] tbl_mask,
  input  logic [SUB_W-1:0]  sub_idx,
  output verdict_t          verdict
);

  logic prot;
  logic slice_marked;

  assign prot         = st_fire && st_wp;
  assign slice_marked = tbl_mask[sub_idx];

  always_comb begin
    verdict.code_hit = prot && tbl_hit && slice_marked;
    verdict.page_hit = prot && !tbl_hit;
  end

endmodule

// File: rtl/cwp_event_reg.sv
// Registers N event pulses and latches the address of the latest event.
module cwp_event_reg #(
  parameter int N  = 2,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  ev,
  input  logic [AW-1:0] ev_addr,
  output logic [N-1:0]  pulse_q,
  output logic [AW-1:0] addr_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= '0;
      addr_q  <= '0;
    end else begin
      pulse_q <= ev;
      if (|ev) addr_q <= ev_addr;
    end
  end

endmodule

// File: rtl/cwp_code_write_filter.sv
// Store-path filter for writes into translated guest code.
module cwp_code_write_filter
  import cwp_pkg::*;
#(
  parameter int PPN_W      = 20,
  parameter int OFF_W      = 12,
  parameter int SUB_W      = 4,
  parameter int WP_ENTRIES = 8,
  parameter int IO_ENTRIES = 8,
  localparam int PA_W      = PPN_W + OFF_W,
  localparam int MASK_W    = 1 << SUB_W,
  localparam int WP_IDX_W  = $clog2(WP_ENTRIES),
  localparam int IO_IDX_W  = $clog2(IO_ENTRIES),
  localparam int CFG_IDX_W = (WP_IDX_W > IO_IDX_W) ? WP_IDX_W : IO_IDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 st_valid,
  output logic                 st_ready,
  input  logic [PA_W-1:0]      st_paddr,
  input  logic                 st_wp,
  input  logic                 io_valid,
  input  logic [PA_W-1:0]      io_paddr,
  input  logic                 cfg_we,
  input  logic                 cfg_sel,
  input  logic [CFG_IDX_W-1:0] cfg_idx,
  input  logic                 cfg_valid,
  input  logic [PPN_W-1:0]     cfg_ppn,
  input  logic [MASK_W-1:0]    cfg_mask,
  output logic                 flt_code,
  output logic                 flt_page,
  output logic [PA_W-1:0]      flt_addr,
  output logic                 io_irq,
  output logic [PA_W-1:0]      io_irq_addr
);

  logic              fine_we;
  logic              io_we;
  logic              fine_hit;
  logic [MASK_W-1:0] fine_mask;
  logic              io_hit;
  logic [0:0]        io_mark;
  verdict_t          verdict;
  logic [1:0]        flt_ev;
  logic [1:0]        flt_q;
  logic [0:0]        irq_ev;
  logic [0:0]        irq_q;

  // The filter never stalls the store stream.
  assign st_ready = 1'b1;

  assign fine_we = cfg_we && (tbl_sel_e'(cfg_sel) == TBL_FINE);
  assign io_we   = cfg_we && (tbl_sel_e'(cfg_sel) == TBL_IO);

  cwp_tag_table #(
    .ENTRIES (WP_ENTRIES),
    .TAG_W   (PPN_W),
    .MASK_W  (MASK_W)
  ) u_fine_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (fine_we),
    .wr_idx   (cfg_idx[WP_IDX_W-1:0]),
    .wr_valid (cfg_valid),
    .wr_tag   (cfg_ppn),
    .wr_mask  (cfg_mask),
    .lk_tag   (st_paddr[PA_W-1:OFF_W]),
    .lk_hit   (fine_hit),
    .lk_mask  (fine_mask)
  );

  // Code-page list for I/O writes: a single always-set mark per entry.
  cwp_tag_table #(
    .ENTRIES (IO_ENTRIES),
    .TAG_W   (PPN_W),
    .MASK_W  (1)
  ) u_io_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (io_we),
    .wr_idx   (cfg_idx[IO_IDX_W-1:0]),
    .wr_valid (cfg_valid),
    .wr_tag   (cfg_ppn),
    .wr_mask  (1'b1),
    .lk_tag   (io_paddr[PA_W-1:OFF_W]),
    .lk_hit   (io_hit),
    .lk_mask  (io_mark)
  );

  cwp_compare #(
    .SUB_W (SUB_W)
  ) u_cmp (
    .st_fire  (st_valid && st_ready),
    .st_wp    (st_wp),
    .tbl_hit  (fine_hit),
    .tbl_mask (fine_mask),
    .sub_idx  (st_paddr[OFF_W-1:OFF_W-SUB_W]),
    .verdict  (verdict)
  );

  assign flt_ev = {verdict.page_hit, verdict.code_hit};

  cwp_event_reg #(
    .N  (2),
    .AW (PA_W)
  ) u_flt_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (flt_ev),
    .ev_addr (st_paddr),
    .pulse_q (flt_q),
    .addr_q  (flt_addr)
  );

  assign flt_code = flt_q[0];
  assign flt_page = flt_q[1];

  assign irq_ev[0] = io_valid && io_hit && io_mark[0];

  cwp_event_reg #(
    .N  (1),
    .AW (PA_W)
  ) u_irq_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (irq_ev),
    .ev_addr (io_paddr),
    .pulse_q (irq_q),
    .addr_q  (io_irq_addr)
  );

  assign io_irq = irq_q[0];

endmodule

// File: rtl/cwp_code_write_filter_chk.sv
module cwp_code_write_filter_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            st_valid,
  input logic            st_wp,
  input logic            io_valid,
  input logic            flt_code,
  input logic            flt_page,
  input logic [PA_W-1:0] flt_addr,
  input logic            io_irq,
  input logic [PA_W-1:0] io_irq_addr
);

  // R2
  unprot_store_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_wp) |=> (!flt_code && !flt_page));

  // R10
  idle_store_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st_valid |=> (!flt_code && !flt_page));

  // R3
  code_fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_code |-> $past(st_valid && st_wp));

  // R5
  fault_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(flt_code && flt_page));

  // R9
  flt_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flt_code && !flt_page) |-> $stable(flt_addr));

  // R9
  irq_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_irq |-> $stable(io_irq_addr));

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_valid |=> !io_irq);

endmodule

bind cwp_code_write_filter cwp_code_write_filter_chk #(
  .PA_W (PA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .st_valid    (st_valid),
  .st_wp       (st_wp),
  .io_valid    (io_valid),
  .flt_code    (flt_code),
  .flt_page    (flt_page),
  .flt_addr    (flt_addr),
  .io_irq      (io_irq),
  .io_irq_addr (io_irq_addr)
);

// File: tb/cwp_code_write_filter_bench.sv
`timescale 1ns/1ps
module cwp_code_write_filter_bench;

  localparam int PPN_W = 20;
  localparam int PA_W  = 32;
  localparam int NENT  = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            st_valid = 1'b0;
  logic            st_ready;
  logic [PA_W-1:0] st_paddr = '0;
  logic            st_wp = 1'b0;
  logic            io_valid = 1'b0;
  logic [PA_W-1:0] io_paddr = '0;
  logic            cfg_we = 1'b0;
  logic            cfg_sel = 1'b0;
  logic [2:0]      cfg_idx = '0;
  logic            cfg_valid = 1'b0;
  logic [PPN_W-1:0] cfg_ppn = '0;
  logic [15:0]     cfg_mask = '0;
  logic            flt_code;
  logic            flt_page;
  logic [PA_W-1:0] flt_addr;
  logic            io_irq;
  logic [PA_W-1:0] io_irq_addr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // Reference model of both tables
  bit          f_v [NENT];
  logic [19:0] f_ppn [NENT];
  logic [15:0] f_mask [NENT];
  bit          i_v [NENT];
  logic [19:0] i_ppn [NENT];
  logic [PA_W-1:0] exp_faddr = '0;
  logic [PA_W-1:0] exp_iaddr = '0;

  always #10 clk = ~clk; // 50 MHz

  cwp_code_write_filter u_cwp_code_write_filter (
    .clk (clk), .rst_n (rst_n),
    .st_valid (st_valid), .st_ready (st_ready), .st_paddr (st_paddr), .st_wp (st_wp),
    .io_valid (io_valid), .io_paddr (io_paddr),
    .cfg_we (cfg_we), .cfg_sel (cfg_sel), .cfg_idx (cfg_idx), .cfg_valid (cfg_valid),
    .cfg_ppn (cfg_ppn), .cfg_mask (cfg_mask),
    .flt_code (flt_code), .flt_page (flt_page), .flt_addr (flt_addr),
    .io_irq (io_irq), .io_irq_addr (io_irq_addr)
  );

  task automatic check(input string tag, input logic [PA_W-1:0] act, input logic [PA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg(input bit sel, input int idx, input bit v,
                     input logic [19:0] ppn, input logic [15:0] mask);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_idx = 3'(idx); cfg_valid = v;
    cfg_ppn = ppn; cfg_mask = mask;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel) begin i_v[idx] = v; i_ppn[idx] = ppn; end
    else begin f_v[idx] = v; f_ppn[idx] = ppn; f_mask[idx] = mask; end
  endtask

  function automatic logic [1:0] model_store(input logic [19:0] ppn, input int sub, input bit wp);
    bit hit = 1'b0;
    logic [15:0] m = '0;
    for (int i = 0; i < NENT; i++)
      if (f_v[i] && f_ppn[i] == ppn) begin hit = 1'b1; m = m | f_mask[i]; end
    if (!wp) return 2'b00;
    if (!hit) return 2'b10;
    return {1'b0, m[sub]};
  endfunction

  // Present one store, then check outputs one cycle later.
  task automatic store_chk(input logic [19:0] ppn, input int sub, input bit wp,
                           input bit vld, input string tag_in);
    logic [1:0] e;
    logic [PA_W-1:0] a;
    string tag;
    a = {ppn, 4'(sub), 8'((sub * 37 + 5) & 8'hff)};
    e = vld ? model_store(ppn, sub, wp) : 2'b00;
    if (tag_in != "") tag = tag_in;
    else if (!wp) tag = "R2";
    else if (e[1]) tag = "R5";
    else if (e[0]) tag = "R3";
    else tag = "R4";
    @(negedge clk);
    st_valid = vld; st_wp = wp; st_paddr = a;
    @(negedge clk);
    st_valid = 1'b0;
    if (e != 2'b00) exp_faddr = a;
    check({tag, " flt_page,flt_code"}, PA_W'({flt_page, flt_code}), PA_W'(e));
    check({tag, " R9 flt_addr"}, flt_addr, exp_faddr);
  endtask

  task automatic io_chk(input logic [19:0] ppn, input string tag);
    bit hit = 1'b0;
    logic [PA_W-1:0] a;
    a = {ppn, 12'h3c4};
    for (int i = 0; i < NENT; i++) if (i_v[i] && i_ppn[i] == ppn) hit = 1'b1;
    @(negedge clk);
    io_valid = 1'b1; io_paddr = a;
    @(negedge clk);
    io_valid = 1'b0;
    if (hit) exp_iaddr = a;
    check({tag, " io_irq"}, PA_W'(io_irq), PA_W'(hit));
    check({tag, " R9 io_irq_addr"}, io_irq_addr, exp_iaddr);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NENT; i++) begin f_v[i] = 0; i_v[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 flt_code", PA_W'(flt_code), 0);
    check("R1 flt_page", PA_W'(flt_page), 0);
    check("R1 io_irq", PA_W'(io_irq), 0);
    check("R1 flt_addr", flt_addr, 0);
    check("R1 io_irq_addr", io_irq_addr, 0);
    check("R10 st_ready", PA_W'(st_ready), 1);
    rst_n = 1'b1;
    // R1: empty table gives a coarse fault
    store_chk(20'h00100, 3, 1'b1, 1'b1, "R1");

    // Load fine table: page 0x100+i, mask computed from the index
    for (int i = 0; i < NENT; i++)
      cfg(1'b0, i, 1'b1, 20'h00100 + 20'(i), 16'((16'h0001 << i) | (16'h8000 >> i) | 16'h0100));

    // Sweep pages (including one absent), slices and wp values
    for (int p = 0; p <= NENT; p++)
      for (int s = 0; s < 16; s++)
        for (int w = 0; w < 2; w++)
          store_chk(20'h00100 + 20'(p), s, w[0], 1'b1, "");

    // R10: idle cycle with a faulting address
    store_chk(20'h00100, 0, 1'b1, 1'b0, "R10");
    store_chk(20'h00155, 0, 1'b1, 1'b0, "R10");

    // R11: duplicate page in entry 7 merges masks with entry 0
    cfg(1'b0, 7, 1'b1, 20'h00100, 16'h0040);
    store_chk(20'h00100, 6, 1'b1, 1'b1, "R11");
    store_chk(20'h00100, 0, 1'b1, 1'b1, "R11");
    store_chk(20'h00100, 5, 1'b1, 1'b1, "R11");

    // R6: invalidate entry 3
    cfg(1'b0, 3, 1'b0, 20'h00103, 16'hffff);
    store_chk(20'h00103, 3, 1'b1, 1'b1, "R6");
    store_chk(20'h00103, 8, 1'b1, 1'b1, "R6");

    // R7: write and store to the same page in the same cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_idx = 3'd3; cfg_valid = 1'b1;
    cfg_ppn = 20'h00777; cfg_mask = 16'hffff;
    st_valid = 1'b1; st_wp = 1'b1; st_paddr = 32'h00777_a10;
    @(negedge clk);
    cfg_we = 1'b0; st_valid = 1'b0;
    f_v[3] = 1'b1; f_ppn[3] = 20'h00777; f_mask[3] = 16'hffff;
    exp_faddr = 32'h00777_a10;
    check("R7 same-cycle old contents flt_page", PA_W'(flt_page), 1);
    check("R7 same-cycle flt_code", PA_W'(flt_code), 0);
    store_chk(20'h00777, 10, 1'b1, 1'b1, "R7");
    // R3: pulse lasts exactly one cycle
    @(negedge clk);
    check("R3 pulse width", PA_W'(flt_code), 0);

    // R8: I/O code-page table
    for (int i = 0; i < NENT; i++) cfg(1'b1, i, 1'b1, 20'h00200 + 20'(i), 16'h0);
    for (int p = 0; p <= NENT; p++) io_chk(20'h00200 + 20'(p), "R8");
    io_chk(20'h00101, "R8 fine-only page");
    cfg(1'b1, 2, 1'b0, 20'h00202, 16'h0);
    io_chk(20'h00202, "R8 invalidated");
    io_chk(20'h00205, "R8");
    // R2: a store never triggers the I/O interrupt
    store_chk(20'h00204, 1, 1'b1, 1'b1, "R8 store");
    check("R8 io_irq after store", PA_W'(io_irq), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule